// File: doc/BRIEF.md
# Configuration Switch Override Controller

This block is a byte-wide register bank for a board-control FPGA. It mirrors eight groups of eight physical configuration switches. For each switch bit, software chooses between the physical level and a value it has written. It does this through a pair of registers per group: a value byte and an enable byte. The merged result is driven out all the time as the effective board configuration.

The block can also start a board reset, which holds a reset output high for a fixed number of cycles. There are two ways to start one. Any write to the hard-reset register starts a reset that takes its boot configuration from the physical switches only, with every enable ignored. A rising edge written into bit 0 of the sequencer control register starts a reset that takes the override-merged configuration. In both cases the chosen configuration is frozen on a boot-configuration output for use by the rest of the board.

A 24-bit clock-synthesizer word is held in three byte registers. It is presented with a valid flag, which is bit 0 of a clock-enable register.

Top module: `cfg_override_ctrl`

## Requirements
- R1: Every bit of `cfg_eff` equals the software value bit when the matching enable bit is 1, and equals the synchronized physical switch bit when it is 0. Switch value n is at address 0x10+2n and switch enable n at 0x11+2n. Group n occupies `cfg_eff[8n+7:8n]`.
- R2: The physical switches pass through two flip-flops. A change on `sw_phys` reaches `cfg_eff` after the second rising clock edge.
- R3: A write of any data to address 0x01 starts a hard reset. `board_rst` is high from the next cycle for exactly 16 cycles. `boot_cfg` latches the synchronized physical switches and ignores all enables.
- R4: A write to address 0x02 with data bit 0 = 1 starts a sequenced reset only when the stored bit 0 is 0. `board_rst` then behaves as in R3 and `boot_cfg` latches the merged `cfg_eff` value. A write of 1 while the stored bit is already 1 has no effect.
- R5: A trigger that arrives while `board_rst` is high neither extends the pulse nor changes `boot_cfg`.
- R6: `clk_word[23:16]`, `[15:8]` and `[7:0]` come from addresses 0x04, 0x05 and 0x06. `clk_word_valid` is bit 0 of address 0x03.
- R7: Reads return the last written byte of addresses 0x01 to 0x06 and 0x10 to 0x1F. Address 0x00 returns `ID_VALUE`. Address 0x07 returns {7'b0, board_rst}. Writes to 0x00 and 0x07 are ignored. Every other address reads 0.
- R8: After `rst_n` is released, all registers are 0. The physical switches then drive `cfg_eff`, and `board_rst`, `boot_cfg` and `clk_word_valid` are 0.
- R9: `req_ready` is always 1. Each accepted read gives exactly one `rsp_valid` pulse, with `rsp_data`, in the next cycle. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| sw_phys | input | 64 | Physical switch levels, asynchronous |
| cfg_eff | output | 64 | Live merged configuration |
| boot_cfg | output | 64 | Configuration frozen at the last reset trigger |
| board_rst | output | 1 | Board reset pulse |
| clk_word | output | 24 | Clock-synthesizer word |
| clk_word_valid | output | 1 | Clock word may be used |

## Verification
A corrupted value or enable byte appears on `cfg_eff` in the same cycle. It appears on the next read of that address one cycle later. A wrong trigger detector or pulse counter shows on `board_rst` at the edge after the offending write, or at the 16th cycle of the pulse. A wrong source selection for the latched configuration appears on `boot_cfg` right after the trigger. The bench's reference model is compared against every output on every clock, so each of these shows up in the cycle it first becomes visible.

// File: rtl/cfg_ovr_pkg.sv
package cfg_ovr_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_ID      = 8'h00;
  localparam logic [ADDR_W-1:0] A_HRST    = 8'h01;
  localparam logic [ADDR_W-1:0] A_SEQ     = 8'h02;
  localparam logic [ADDR_W-1:0] A_CKEN    = 8'h03;
  localparam logic [ADDR_W-1:0] A_CKW0    = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h07;
  localparam logic [ADDR_W-1:0] A_SW_BASE = 8'h10;
  localparam int CK_BYTES = 3;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cfg_merge.sv
module cfg_merge #(
  parameter int NUM_GRP = 8,
  parameter int DATA_W  = 8
) (
  input  logic [NUM_GRP*DATA_W-1:0] phys,
  input  logic [NUM_GRP*DATA_W-1:0] val,
  input  logic [NUM_GRP*DATA_W-1:0] en,
  output logic [NUM_GRP*DATA_W-1:0] eff
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int IDX = g*DATA_W + b;
      assign eff[IDX] = en[IDX] ? val[IDX] : phys[IDX];
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_ovr_pkg::*;
#(
  parameter int                NUM_GRP  = 8,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        rst_busy,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_GRP*DATA_W-1:0]   sw_val,
  output logic [NUM_GRP*DATA_W-1:0]   sw_en,
  output logic [CK_BYTES*DATA_W-1:0]  ck_word,
  output logic                        ck_valid,
  output logic                        hard_trig,
  output logic                        seq_trig
);
  logic [DATA_W-1:0] hrst_q, seq_q, cken_q;
  logic [DATA_W-1:0] ck_q [CK_BYTES];

  assign hard_trig = wr_en && (addr == A_HRST);
  assign seq_trig  = wr_en && (addr == A_SEQ) && wdata[0] && !seq_q[0];
  assign ck_valid  = cken_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrst_q <= '0;
      seq_q  <= '0;
      cken_q <= '0;
    end else if (wr_en) begin
      if (addr == A_HRST) hrst_q <= wdata;
      if (addr == A_SEQ)  seq_q  <= wdata;
      if (addr == A_CKEN) cken_q <= wdata;
    end
  end

  for (genvar k = 0; k < CK_BYTES; k++) begin : g_ck
    localparam logic [ADDR_W-1:0] A_K = A_CKW0 + ADDR_W'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ck_q[k] <= '0;
      else if (wr_en && (addr == A_K)) ck_q[k] <= wdata;
    end
    // byte 0 is the most significant
    assign ck_word[(CK_BYTES-1-k)*DATA_W +: DATA_W] = ck_q[k];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sw
    localparam logic [ADDR_W-1:0] A_VAL = A_SW_BASE + ADDR_W'(2*g);
    localparam logic [ADDR_W-1:0] A_ENB = A_SW_BASE + ADDR_W'(2*g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_val[g*DATA_W +: DATA_W] <= '0;
        sw_en[g*DATA_W +: DATA_W]  <= '0;
      end else if (wr_en) begin
        if (addr == A_VAL) sw_val[g*DATA_W +: DATA_W] <= wdata;
        if (addr == A_ENB) sw_en[g*DATA_W +: DATA_W]  <= wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_ID)   rd_data = ID_VALUE;
    if (addr == A_HRST) rd_data = hrst_q;
    if (addr == A_SEQ)  rd_data = seq_q;
    if (addr == A_CKEN) rd_data = cken_q;
    if (addr == A_STAT) rd_data = DATA_W'(rst_busy);
    for (int k = 0; k < CK_BYTES; k++) begin
      if (addr == A_CKW0 + ADDR_W'(k)) rd_data = ck_q[k];
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr == A_SW_BASE + ADDR_W'(2*g))     rd_data = sw_val[g*DATA_W +: DATA_W];
      if (addr == A_SW_BASE + ADDR_W'(2*g + 1)) rd_data = sw_en[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cfg_rst_seq.sv
module cfg_rst_seq #(
  parameter int CFG_W      = 64,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_trig,
  input  logic             seq_trig,
  input  logic [CFG_W-1:0] phys_cfg,
  input  logic [CFG_W-1:0] merged_cfg,
  output logic             busy,
  output logic [CFG_W-1:0] boot_cfg
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] remain;

  assign busy = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain   <= '0;
      boot_cfg <= '0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end else if (hard_trig || seq_trig) begin
      remain   <= CNT_W'(RST_CYCLES);
      boot_cfg <= hard_trig ? phys_cfg : merged_cfg;
    end
  end
endmodule

// File: rtl/cfg_override_ctrl.sv
module cfg_override_ctrl
  import cfg_ovr_pkg::*;
#(
  parameter int          NUM_GRP    = 8,
  parameter int          DATA_W     = 8,
  parameter int          RST_CYCLES = 16,
  parameter logic [7:0]  ID_VALUE   = 8'hA5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_we,
  input  logic [7:0]                  req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  input  logic [NUM_GRP*DATA_W-1:0]   sw_phys,
  output logic [NUM_GRP*DATA_W-1:0]   cfg_eff,
  output logic [NUM_GRP*DATA_W-1:0]   boot_cfg,
  output logic                        board_rst,
  output logic [CK_BYTES*DATA_W-1:0]  clk_word,
  output logic                        clk_word_valid
);
  localparam int CFG_W = NUM_GRP * DATA_W;

  logic [CFG_W-1:0]  phys_s, sw_val, sw_en;
  logic [DATA_W-1:0] rd_data;
  logic              hard_trig, seq_trig, wr_en, rd_en;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_we;
  assign rd_en     = req_valid && !req_we;

  cfg_sync2 #(.W(CFG_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_phys), .q(phys_s)
  );

  cfg_regfile #(.NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .ID_VALUE(DATA_W'(ID_VALUE))) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr), .wdata(req_wdata),
    .rst_busy(board_rst), .rd_data(rd_data), .sw_val(sw_val), .sw_en(sw_en),
    .ck_word(clk_word), .ck_valid(clk_word_valid),
    .hard_trig(hard_trig), .seq_trig(seq_trig)
  );

  cfg_merge #(.NUM_GRP(NUM_GRP), .DATA_W(DATA_W)) u_merge (
    .phys(phys_s), .val(sw_val), .en(sw_en), .eff(cfg_eff)
  );

  cfg_rst_seq #(.CFG_W(CFG_W), .RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .hard_trig(hard_trig), .seq_trig(seq_trig),
    .phys_cfg(phys_s), .merged_cfg(cfg_eff), .busy(board_rst), .boot_cfg(boot_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_data;
    end
  end
endmodule

// File: rtl/cfg_override_chk.sv
module cfg_override_chk #(
  parameter int         CFG_W      = 64,
  parameter int         RST_CYCLES = 16,
  parameter logic [7:0] ID_VALUE   = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_we,
  input logic [7:0]       req_addr,
  input logic             rsp_valid,
  input logic [7:0]       rsp_data,
  input logic             board_rst,
  input logic [CFG_W-1:0] boot_cfg,
  input logic             clk_word_valid
);
  localparam int CW = $clog2(RST_CYCLES + 1) + 1;
  logic [CW-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         high_run <= '0;
    else if (board_rst) high_run <= high_run + 1'b1;
    else                high_run <= '0;
  end

  assert_hrst_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == 8'h01 && !board_rst) |=> board_rst);

  assert_pulse_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> (high_run < CW'(RST_CYCLES)));

  assert_pulse_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_rst) |-> (high_run == CW'(RST_CYCLES)));

  assert_boot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(board_rst) && board_rst) |-> $stable(boot_cfg));

  assert_ckvalid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_we && req_addr == 8'h03) |=> $stable(clk_word_valid));

  assert_id_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_addr == 8'h00) |=> (rsp_data == ID_VALUE));

  assert_rsp_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  assert_rsp_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind cfg_override_ctrl cfg_override_chk #(
  .CFG_W(NUM_GRP*DATA_W), .RST_CYCLES(RST_CYCLES), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .board_rst(board_rst), .boot_cfg(boot_cfg), .clk_word_valid(clk_word_valid)
);

// File: tb/tb_cfg_override_ctrl.sv
module tb_cfg_override_ctrl;
  localparam logic [7:0] ID = 8'hA5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_we = 0;
  logic [7:0]  req_addr = 0, req_wdata = 0;
  logic        req_ready, rsp_valid, board_rst, clk_word_valid;
  logic [7:0]  rsp_data;
  logic [63:0] sw_phys = 64'h0123_4567_89AB_CDEF;
  logic [63:0] cfg_eff, boot_cfg;
  logic [23:0] clk_word;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  cfg_override_ctrl #(.ID_VALUE(ID)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sw_phys(sw_phys),
    .cfg_eff(cfg_eff), .boot_cfg(boot_cfg), .board_rst(board_rst),
    .clk_word(clk_word), .clk_word_valid(clk_word_valid)
  );

  // behavioural reference model
  logic [63:0] m_s1, m_s2, m_val, m_en, m_boot;
  logic [7:0]  m_hrst, m_seq, m_cken, m_ck [3];
  int          m_cnt;
  logic        m_rv;
  logic [7:0]  m_rd;

  function automatic logic [63:0] pick(input logic [63:0] p, v, e);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = e[i] ? v[i] : p[i];
    return r;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a == 8'h00) return ID;
    if (a == 8'h01) return m_hrst;
    if (a == 8'h02) return m_seq;
    if (a == 8'h03) return m_cken;
    if (a >= 8'h04 && a <= 8'h06) return m_ck[a-4];
    if (a == 8'h07) return {7'b0, m_cnt != 0};
    if (a >= 8'h10 && a <= 8'h1F)
      return a[0] ? m_en[((a-16)/2)*8 +: 8] : m_val[((a-16)/2)*8 +: 8];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_val <= 0; m_en <= 0; m_boot <= 0;
      m_hrst <= 0; m_seq <= 0; m_cken <= 0; m_cnt <= 0; m_rv <= 0; m_rd <= 0;
      for (int k = 0; k < 3; k++) m_ck[k] <= 0;
    end else begin
      logic hard, seqt;
      m_s1 <= sw_phys;
      m_s2 <= m_s1;
      m_rv <= req_valid && !req_we;
      if (req_valid && !req_we) m_rd <= mread(req_addr);
      hard = req_valid && req_we && req_addr == 8'h01;
      seqt = req_valid && req_we && req_addr == 8'h02 && req_wdata[0] && !m_seq[0];
      if (req_valid && req_we) begin
        if (req_addr == 8'h01) m_hrst <= req_wdata;
        if (req_addr == 8'h02) m_seq <= req_wdata;
        if (req_addr == 8'h03) m_cken <= req_wdata;
        if (req_addr >= 8'h04 && req_addr <= 8'h06) m_ck[req_addr-4] <= req_wdata;
        if (req_addr >= 8'h10 && req_addr <= 8'h1F) begin
          if (req_addr[0]) m_en[((req_addr-16)/2)*8 +: 8] <= req_wdata;
          else             m_val[((req_addr-16)/2)*8 +: 8] <= req_wdata;
        end
      end
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
      else if (hard || seqt) begin
        m_cnt  <= 16;
        m_boot <= hard ? m_s2 : pick(m_s2, m_val, m_en);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [63:0] e_eff;
      e_eff = pick(m_s2, m_val, m_en);
      chk(cfg_eff === e_eff, "R1/R2 cfg_eff", cfg_eff, e_eff);
      chk(board_rst === (m_cnt != 0), "R3/R4/R5 board_rst", 64'(board_rst), 64'(m_cnt != 0));
      chk(boot_cfg === m_boot, "R3/R4/R5 boot_cfg", boot_cfg, m_boot);
      chk(clk_word === {m_ck[0], m_ck[1], m_ck[2]}, "R6 clk_word",
          64'(clk_word), 64'({m_ck[0], m_ck[1], m_ck[2]}));
      chk(clk_word_valid === m_cken[0], "R6 clk_word_valid", 64'(clk_word_valid), 64'(m_cken[0]));
      chk(rsp_valid === m_rv, "R9 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk(rsp_data === m_rd, "R7 rsp_data", 64'(rsp_data), 64'(m_rd));
      chk(req_ready === 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    #2 req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    #2 req_valid = 0; req_we = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    #2 req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk);
    #2 req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R8: reset state
    chk(board_rst === 0, "R8 board_rst after reset", 64'(board_rst), 0);
    chk(boot_cfg === 0, "R8 boot_cfg after reset", boot_cfg, 0);
    chk(clk_word_valid === 0, "R8 clk_word_valid after reset", 64'(clk_word_valid), 0);
    chk(cfg_eff === sw_phys, "R8 cfg_eff follows switches", cfg_eff, sw_phys);
    for (int a = 0; a < 34; a++) rd(8'(a));
    // R2: switch changes propagate through the synchronizer
    #3 sw_phys = 64'hFFFF_0000_AAAA_5555;
    idle(3);
    #3 sw_phys = 64'h0F0F_F0F0_1234_8765;
    idle(1);
    // R1: overrides
    wr(8'h14, 8'hF0); wr(8'h15, 8'h3C);
    wr(8'h1E, 8'hAA); wr(8'h1F, 8'hFF);
    wr(8'h10, 8'h55);
    for (int a = 16; a < 32; a++) rd(8'(a));
    // R3: hard reset ignores enables
    wr(8'h01, 8'h5A);
    idle(4);
    wr(8'h01, 8'h00);           // R5: retrigger while busy
    rd(8'h07);
    wr(8'h02, 8'h00); wr(8'h02, 8'h01); // R5: sequence rise while busy
    idle(14);
    // R4: already 1, no trigger
    wr(8'h02, 8'h01);
    idle(3);
    wr(8'h02, 8'h00);
    #3 sw_phys = 64'h8000_0000_0000_0001;
    idle(3);
    wr(8'h02, 8'h03);           // R4: sequenced reset with overrides
    rd(8'h07); rd(8'h02);
    idle(20);
    // R6: clock word
    wr(8'h04, 8'h12); wr(8'h05, 8'h34); wr(8'h06, 8'h56);
    wr(8'h03, 8'h01);
    rd(8'h04); rd(8'h05); rd(8'h06); rd(8'h03);
    wr(8'h03, 8'hFE);
    // R7: read-only and unmapped
    wr(8'h00, 8'hFF); wr(8'h07, 8'hFF); wr(8'h30, 8'h77);
    rd(8'h00); rd(8'h07); rd(8'h30); rd(8'h08); rd(8'h20);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 3 == 0) ? 8'($urandom % 8) : 8'(8'h10 + $urandom % 18);
      if ($urandom % 5 == 0) #3 sw_phys = {$urandom, $urandom};
      if ($urandom % 2) wr(a, 8'($urandom)); else rd(a);
      if ($urandom % 4 == 0) idle(1);
    end
    idle(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end
endmodule